// File: doc/BRIEF.md
# Odd-Ratio Half-Duty Clock Divider

This block turns a fast input clock into a slower one whose period is three or five input cycles, chosen by one select pin. An odd ratio cannot give an even split of whole input cycles between the high and low halves. The block therefore ends each high phase on a falling input edge, which yields a high time of 1.5 or 2.5 input periods and a duty cycle near one half.

Output gating is synchronous. Raising the enable starts the output cleanly. Lowering it lets the period in progress run to its end, so no shortened pulse ever appears. An active-low reset acts without a clock and parks the output low. A complement output is provided next to the true output for a differential driver.

Drive the select, enable and reset pins from logic in the input clock domain. A change of the select pin is safe at any time, because the block picks up the new ratio only when the next output period begins.

Top module: `odd_ratio_clkdiv`

## Requirements
- R1: With `sel_five` = 0 the output period is 3 input cycles, and with `sel_five` = 1 it is 5 input cycles. Each period begins with the output rising on an input rising edge.
- R2: At ratio 3 the output is high for 1.5 input periods. It falls on the falling input edge of the second input cycle of its period.
- R3: At ratio 5 the output is high for 2.5 input periods. It falls on the falling input edge of the third input cycle of its period.
- R4: While `rst_n` is 0, `clk_out` is 0 and `clk_out_n` is 1, whatever `enable` and `sel_five` do. Asserting `rst_n` changes the outputs at once, with no clock edge needed.
- R5: While the block is stopped and `enable` stays 0, `clk_out` stays 0.
- R6: Suppose `enable` is raised between two input rising edges while the output is stopped. The first output rising edge then comes on the second input rising edge after that point, after the enable has been seen by one rising and one falling input edge.
- R7: Lowering `enable` never shortens a pulse. The period in progress completes. The output then stays low from the first period boundary whose preceding rising and falling input edges both saw `enable` at 0. An enable pulse one input cycle wide gives exactly one full output period.
- R8: A change of `sel_five` while the output runs leaves the current period at its old ratio. The new ratio applies from the next period boundary.
- R9: `clk_out_n` is always the exact inverse of `clk_out`.
- R10: After `rst_n` is released with `enable` high, the count restarts from zero. The first output rising edge comes on the second input rising edge after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided; both of its edges are used |
| rst_n | input | 1 | Asynchronous active-low reset; forces the output low |
| sel_five | input | 1 | Ratio select: 0 gives divide by 3, 1 gives divide by 5 |
| enable | input | 1 | Synchronous output enable, active high |
| clk_out | output | 1 | Divided clock, true polarity |
| clk_out_n | output | 1 | Divided clock, complement polarity |

## Verification
The assertions assume that `enable` and `sel_five` change only in the half cycle after an input rising edge, and that `rst_n` is released away from any input clock edge, so that both register stages see clean values. The stimulus keeps to this. Every input is driven 1 ns after a rising edge of the 8 ns clock, except that reset is asserted 3 ns after a rising edge on purpose, to show that it acts without a clock. Outputs are sampled 2 ns after each clock edge, so each half-period of the output is checked against a precomputed waveform.

// File: rtl/odd_ratio_clkdiv_pkg.sv
package odd_ratio_clkdiv_pkg;

   // index of the ratio table: low ratio at 0, high ratio at 1
   typedef enum logic {
      RATIO_SEL_LO = 1'b0,
      RATIO_SEL_HI = 1'b1
   } ratio_sel_e;

   // number of whole input cycles the lead stage stays high
   function automatic int lead_span(input int ratio);
      return (ratio - 1) / 2;
   endfunction

   function automatic bit ratio_ok(input int ratio);
      return (ratio >= 3) && ((ratio % 2) == 1);
   endfunction

endpackage

// File: rtl/odiv_enable_sync.sv
// Two-edge enable capture: one rising edge, then one falling edge.
module odiv_enable_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic armed_o
);

   logic rise_q;
   logic fall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rise_q <= 1'b0;
      else        rise_q <= en_i;
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) fall_q <= 1'b0;
      else        fall_q <= rise_q;
   end

   assign armed_o = fall_q;

endmodule

// File: rtl/odiv_period_ctrl.sv
// Rising-edge period sequencer: counts input cycles, latches the ratio at
// each period start and drives the lead (whole-cycle) high phase.
module odiv_period_ctrl
   import odd_ratio_clkdiv_pkg::*;
#(
   parameter int RATIO_LO = 3,
   parameter int RATIO_HI = 5,
   parameter int CNT_W    = $clog2(RATIO_HI)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_hi_i,
   input  logic armed_i,
   output logic lead_o,
   output logic run_o,
   output logic ratio_hi_o
);

   logic [CNT_W-1:0] last_tbl [2];
   logic [CNT_W-1:0] span_tbl [2];

   for (genvar g = 0; g < 2; g++) begin : g_ratio_tbl
      localparam int RATIO = (g == 0) ? RATIO_LO : RATIO_HI;
      assign last_tbl[g] = CNT_W'(RATIO - 1);
      assign span_tbl[g] = CNT_W'(lead_span(RATIO));
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             run_q;
   logic             lead_q;
   ratio_sel_e       ratio_q;
   logic             at_end;

   assign cnt_inc = cnt_q + 1'b1;
   assign at_end  = (cnt_q == last_tbl[ratio_q]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         cnt_q   <= '0;
         lead_q  <= 1'b0;
         ratio_q <= RATIO_SEL_LO;
      end else if (!run_q || at_end) begin
         if (armed_i) begin
            run_q   <= 1'b1;
            cnt_q   <= '0;
            lead_q  <= 1'b1;
            ratio_q <= ratio_sel_e'(sel_hi_i);
         end else begin
            run_q   <= 1'b0;
            cnt_q   <= '0;
            lead_q  <= 1'b0;
         end
      end else begin
         cnt_q  <= cnt_inc;
         lead_q <= (cnt_inc < span_tbl[ratio_q]);
      end
   end

   assign lead_o     = lead_q;
   assign run_o      = run_q;
   assign ratio_hi_o = (ratio_q == RATIO_SEL_HI);

endmodule

// File: rtl/odiv_edge_merge.sv
// Falling-edge stretch: extends the lead phase by half an input period.
module odiv_edge_merge (
   input  logic clk,
   input  logic rst_n,
   input  logic lead_i,
   output logic trail_o,
   output logic out_o,
   output logic out_n_o
);

   logic trail_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) trail_q <= 1'b0;
      else        trail_q <= lead_i;
   end

   assign trail_o = trail_q;
   assign out_o   = lead_i | trail_q;
   assign out_n_o = ~(lead_i | trail_q);

endmodule

// File: rtl/odd_ratio_clkdiv.sv
module odd_ratio_clkdiv
   import odd_ratio_clkdiv_pkg::*;
#(
   parameter int RATIO_LO = 3,
   parameter int RATIO_HI = 5
) (
   input  logic clk_in,
   input  logic rst_n,
   input  logic sel_five,
   input  logic enable,
   output logic clk_out,
   output logic clk_out_n
);

   localparam int CNT_W = $clog2(RATIO_HI);

   initial begin
      assert (ratio_ok(RATIO_LO)) else $error("RATIO_LO must be odd and at least 3");
      assert (ratio_ok(RATIO_HI)) else $error("RATIO_HI must be odd and at least 3");
      assert (RATIO_LO < RATIO_HI) else $error("RATIO_LO must be below RATIO_HI");
   end

   logic armed_w;
   logic lead_w;
   logic run_w;
   logic ratio_hi_w;
   logic trail_w;

   odiv_enable_sync u_en_sync (
      .clk     (clk_in),
      .rst_n   (rst_n),
      .en_i    (enable),
      .armed_o (armed_w)
   );

   odiv_period_ctrl #(
      .RATIO_LO (RATIO_LO),
      .RATIO_HI (RATIO_HI),
      .CNT_W    (CNT_W)
   ) u_ctrl (
      .clk        (clk_in),
      .rst_n      (rst_n),
      .sel_hi_i   (sel_five),
      .armed_i    (armed_w),
      .lead_o     (lead_w),
      .run_o      (run_w),
      .ratio_hi_o (ratio_hi_w)
   );

   odiv_edge_merge u_merge (
      .clk     (clk_in),
      .rst_n   (rst_n),
      .lead_i  (lead_w),
      .trail_o (trail_w),
      .out_o   (clk_out),
      .out_n_o (clk_out_n)
   );

endmodule

// File: rtl/odd_ratio_clkdiv_checker.sv
module odd_ratio_clkdiv_checker #(
   parameter int RATIO_LO = 3,
   parameter int RATIO_HI = 5
) (
   input logic clk,
   input logic rst_n,
   input logic clk_out,
   input logic clk_out_n,
   input logic lead,
   input logic trail,
   input logic run,
   input logic ratio_hi
);

   localparam int SPAN_LO = (RATIO_LO - 1) / 2;
   localparam int SPAN_HI = (RATIO_HI - 1) / 2;
   localparam int GAP_LO  = RATIO_LO - SPAN_LO;
   localparam int GAP_HI  = RATIO_HI - SPAN_HI;
   localparam int RUN_W   = $clog2(RATIO_HI + 2);

   logic [RUN_W-1:0] hi_run;
   logic [RUN_W-1:0] lo_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= '0;
      end else begin
         hi_run <= lead ? hi_run + 1'b1 : '0;
         if (lead)                     lo_run <= '0;
         else if (lo_run != '1)        lo_run <= lo_run + 1'b1;
      end
   end

   // R4: reset parks the output pair without any clock
   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_park_R4: assert (clk_out == 1'b0 && clk_out_n == 1'b1)
            else $error("output pair not parked during reset");
      end
   end

   // R2 / R3: the falling-edge stage carries the lead phase half a cycle on
   assert_trail_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trail == lead);

   // R3: whole-cycle high span matches the ratio in force
   assert_lead_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lead) |-> (hi_run == (ratio_hi ? RUN_W'(SPAN_HI) : RUN_W'(SPAN_LO))));

   // R8: no shortened low phase, even when the ratio changes
   assert_no_runt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lead) |-> (lo_run >= ($past(ratio_hi) ? RUN_W'(GAP_HI) : RUN_W'(GAP_LO))));

   // R7: stopping happens only once the output is already low
   assert_stop_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> (!lead && !$past(lead)));

   // R5: a stopped block keeps the output low
   assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && $past(!run)) |-> !clk_out);

endmodule

bind odd_ratio_clkdiv odd_ratio_clkdiv_checker #(
   .RATIO_LO (RATIO_LO),
   .RATIO_HI (RATIO_HI)
) u_checker (
   .clk       (clk_in),
   .rst_n     (rst_n),
   .clk_out   (clk_out),
   .clk_out_n (clk_out_n),
   .lead      (lead_w),
   .trail     (trail_w),
   .run       (run_w),
   .ratio_hi  (ratio_hi_w)
);

// File: tb/odd_ratio_clkdiv_tb_top.sv
`timescale 1ns/100ps
module odd_ratio_clkdiv_tb_top;

   logic clk = 1'b0;
   logic rst_n;
   logic sel_five;
   logic enable;
   logic clk_out;
   logic clk_out_n;

   always #4 clk = ~clk;   // 125 MHz

   odd_ratio_clkdiv dut_i (
      .clk_in    (clk),
      .rst_n     (rst_n),
      .sel_five  (sel_five),
      .enable    (enable),
      .clk_out   (clk_out),
      .clk_out_n (clk_out_n)
   );

   typedef struct {
      int    slot;
      bit    val;
      string req;
   } exp_t;

   exp_t q[$];
   int   slot_cnt = 0;
   int   n_chk    = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;

   function automatic void check(input bit ok, input string req,
                                 input logic act, input logic exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp_v);
      end
   endfunction

   function automatic void push(input int s, input bit v, input string r);
      exp_t e;
      e.slot = s; e.val = v; e.req = r;
      q.push_back(e);
   endfunction

   // monitor: one sample per half input period
   task automatic sample_slot();
      int idx = slot_cnt;
      while (q.size() > 0 && q[0].slot < idx) begin
         exp_t st = q.pop_front();
         check(1'b0, st.req, 1'bx, st.val);
      end
      if (q.size() > 0 && q[0].slot == idx) begin
         exp_t e = q.pop_front();
         check(clk_out === e.val, e.req, clk_out, e.val);
      end
      if (rst_n === 1'b1)
         check(clk_out_n === ~clk_out, "R9", clk_out_n, ~clk_out);
      slot_cnt++;
   endtask

   initial begin
      forever begin
         @(posedge clk); #2; sample_slot();
         @(negedge clk); #2; sample_slot();
      end
   end

   task automatic at_drive(output int k);
      @(posedge clk); #1;
      k = slot_cnt;
   endtask

   task automatic goto_slot(input int s);
      int k;
      do at_drive(k); while (k < s);
   endtask

   // enable or reset release seen at drive slot k: low for four half-periods
   task automatic push_lead_in(input int k, input string r);
      for (int j = 0; j < 4; j++) push(k + j, 1'b0, r);
   endtask

   task automatic push_periods(input int s0, input bit five, input int np, input string r);
      int n = five ? 5 : 3;
      int h = (n - 1) / 2;
      for (int p = 0; p < np; p++)
         for (int j = 0; j < 2 * n; j++)
            push(s0 + p * 2 * n + j, (j < 2 * h + 1), r);
   endtask

   task automatic stop_from(input int b);
      goto_slot(b - 4);
      enable = 1'b0;
      for (int j = 0; j < 8; j++) push(b + j, 1'b0, "R7");
      goto_slot(b + 8);
   endtask

   task automatic run_burst(input bit five, input int np);
      int k, s0;
      at_drive(k);
      sel_five = five;
      enable   = 1'b1;
      push_lead_in(k, "R6");
      s0 = k + 4;
      push_periods(s0, five, np, five ? "R1 R3" : "R1 R2");
      stop_from(s0 + np * 2 * (five ? 5 : 3));
   endtask

   task automatic run_mixed(input bit a, input bit b, input int n1, input int n2);
      int k, s0, s1, na, nb;
      na = a ? 5 : 3;
      nb = b ? 5 : 3;
      at_drive(k);
      sel_five = a;
      enable   = 1'b1;
      push_lead_in(k, "R6");
      s0 = k + 4;
      s1 = s0 + 2 * na * n1;
      push_periods(s0, a, n1, "R8");
      push_periods(s1, b, n2, "R8");
      goto_slot(s1 - 2 * na + 2);   // inside the last old-ratio period
      sel_five = b;
      stop_from(s1 + 2 * nb * n2);
   endtask

   initial begin
      int k, k2, s0;
      rst_n    = 1'b1;
      enable   = 1'b0;
      sel_five = 1'b0;
      #1 rst_n = 1'b0;

      // R4: reset state
      @(negedge clk); #2;
      check(clk_out === 1'b0, "R4", clk_out, 1'b0);
      check(clk_out_n === 1'b1, "R4", clk_out_n, 1'b1);

      // R5: released, enable low, output stays low
      at_drive(k);
      rst_n = 1'b1;
      for (int j = 0; j < 10; j++) push(k + j, 1'b0, "R5");
      goto_slot(k + 10);

      run_burst(1'b0, 3);           // R1 R2 R6 R7
      run_burst(1'b1, 3);           // R1 R3 R6 R7
      run_mixed(1'b0, 1'b1, 2, 2);  // R8
      run_mixed(1'b1, 1'b0, 2, 2);  // R8

      // R7: one-cycle enable pulse gives one full period
      at_drive(k);
      sel_five = 1'b1;
      enable   = 1'b1;
      push_lead_in(k, "R6");
      at_drive(k2);
      enable = 1'b0;
      s0 = k + 4;
      push_periods(s0, 1'b1, 1, "R7");
      for (int j = 0; j < 8; j++) push(s0 + 10 + j, 1'b0, "R7");
      goto_slot(s0 + 18);

      // R4 / R6: reset in mid-pulse acts at once and overrides the pins
      at_drive(k);
      sel_five = 1'b1;
      enable   = 1'b1;
      @(posedge clk);
      @(posedge clk); #3;
      check(clk_out === 1'b1, "R6", clk_out, 1'b1);
      rst_n = 1'b0;
      #0.5;
      check(clk_out === 1'b0, "R4", clk_out, 1'b0);
      check(clk_out_n === 1'b1, "R4", clk_out_n, 1'b1);
      for (int j = 0; j < 4; j++) begin
         @(negedge clk); #2;
         check(clk_out === 1'b0, "R4", clk_out, 1'b0);
         sel_five = ~sel_five;
      end

      // R10: restart after release counts from zero
      at_drive(k);
      sel_five = 1'b0;
      rst_n    = 1'b1;
      push_lead_in(k, "R10");
      s0 = k + 4;
      push_periods(s0, 1'b0, 2, "R10");
      stop_from(s0 + 12);

      run_burst(1'b1, 2);

      repeat (2) @(posedge clk);
      check(q.size() == 0, "R1", 1'b0, 1'b1);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #1_200_000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule